// File: doc/BRIEF.md
# Time-of-Day Alarm Comparator with Repeat Masking

This block holds four alarm bytes (seconds, minutes, hours, day of month). It compares them with a BCD time of day that an external calendar counter supplies. When the selected fields agree on a one-second tick, it raises a single-cycle interrupt pulse. Bit 7 of each alarm byte is a repeat flag. The four flags, read as a set, choose how many fields take part in the comparison. This yields an alarm that fires once a month, once a day, once an hour, once a minute or on every second.

Software reaches the alarm bytes through a byte-wide register port. The port has no handshake: a write strobe is taken in the cycle it is seen, and read data follows the address combinationally. A write is accepted only when the decoded BCD value is in range for its field. Otherwise it is dropped without a trace and the old byte, repeat flag included, is kept. Register offsets are 0 seconds, 1 minutes, 2 hours, 3 day of month.

Top module: `rtc_alarm_match`

## Requirements
- R1: A write to offset 0 (seconds) is stored as the full byte only if its low 7 bits, decoded as tens×10+units (tens = bits 6:4, units = bits 3:0), give 0 to 59; otherwise the old byte is kept.
- R2: A write to offset 1 (minutes) follows the same rule as R1.
- R3: A write to offset 2 (hours) is stored only if its low 6 bits, decoded as tens×10+units (tens = bits 5:4), give 0 to 23; otherwise the old byte is kept.
- R4: A write to offset 3 (day of month) is stored only if its low 6 bits are not zero; otherwise the old byte is kept.
- R5: Reading an offset returns the complete stored byte, bit 7 and any upper bits included.
- R6: While reset is asserted, all four alarm bytes read 0 and the interrupt output is low.
- R7: With all four repeat flags clear, a tick fires only when day, hour, minute and second all equal the alarm fields.
- R8: With only the day flag set, a tick fires when hour, minute and second match, whatever the day.
- R9: With only the day and hour flags set, a tick fires when minute and second match.
- R10: With day, hour and minute flags set and the seconds flag clear, a tick fires when the seconds match.
- R11: Any other set of repeat flags fires on every tick, whatever the time inputs.
- R12: The interrupt is high for exactly the one cycle after a tick cycle whose comparison hit, and is never high without a tick in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for the alarm byte at reg_addr |
| reg_addr | input | 2 | Alarm byte offset for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Stored byte at reg_addr |
| tod_sec | input | 7 | Current seconds, BCD |
| tod_min | input | 7 | Current minutes, BCD |
| tod_hour | input | 6 | Current hours, BCD |
| tod_date | input | 6 | Current day of month, BCD |
| sec_tick | input | 1 | One-cycle pulse once per second |
| alarm_irq | output | 1 | Single-cycle alarm interrupt pulse |

## Verification
The case that is hardest to reach from the ports is a rejected write that carries a repeat flag. An out-of-range byte with bit 7 set must not change the repeat mode either. The only way to see this is through a later tick whose firing depends on the old mode. The stimulus first sets a monthly alarm, then writes such rejected bytes and reads them back. It then ticks with a day mismatch and expects silence. Each repeat mode is then entered by accepted writes, and each mode is probed twice: with the one field it ignores changed, and with a field it still compares changed.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_CNT = 4;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = $clog2(FIELD_CNT);

  typedef enum logic [1:0] {
    F_SEC  = 2'd0,
    F_MIN  = 2'd1,
    F_HOUR = 2'd2,
    F_DATE = 2'd3
  } field_e;

  typedef enum logic [2:0] {
    RPT_MONTH,
    RPT_DAY,
    RPT_HOUR,
    RPT_MINUTE,
    RPT_SECOND
  } repeat_e;

  // tens * 10 + units, as a plain binary value
  function automatic logic [6:0] bcd_value(input logic [6:0] b);
    return ({4'b0, b[6:4]} * 7'd10) + {3'b0, b[3:0]};
  endfunction

  function automatic logic field_ok(input field_e f, input logic [7:0] d);
    logic ok;
    case (f)
      F_SEC, F_MIN: ok = (bcd_value(d[6:0]) <= 7'd59);
      F_HOUR:       ok = (bcd_value({1'b0, d[5:0]}) <= 7'd23);
      default:      ok = (d[5:0] != 6'd0);
    endcase
    return ok;
  endfunction

  // flags = {date, hour, min, sec}
  function automatic repeat_e decode_repeat(input logic [3:0] flags);
    repeat_e m;
    case (flags)
      4'b0000: m = RPT_MONTH;
      4'b1000: m = RPT_DAY;
      4'b1100: m = RPT_HOUR;
      4'b1110: m = RPT_MINUTE;
      default: m = RPT_SECOND;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int N_FIELDS = FIELD_CNT,
  parameter int A_W      = ADDR_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [A_W-1:0]                  wr_addr,
  input  logic [BYTE_W-1:0]               wr_data,
  output logic [N_FIELDS-1:0][BYTE_W-1:0] regs_q
);
  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    logic take;
    assign take = wr_en && (wr_addr == A_W'(g)) && field_ok(field_e'(g), wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    regs_q[g] <= '0;
      else if (take) regs_q[g] <= wr_data;
    end
  end
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import rtc_alarm_pkg::*;
(
  input  logic [6:0] al_sec,
  input  logic [6:0] al_min,
  input  logic [5:0] al_hour,
  input  logic [5:0] al_date,
  input  logic [3:0] flags,
  input  logic [6:0] tod_sec,
  input  logic [6:0] tod_min,
  input  logic [5:0] tod_hour,
  input  logic [5:0] tod_date,
  output logic       hit
);
  logic    eq_s, eq_m, eq_h, eq_d;
  repeat_e mode;

  assign eq_s = (al_sec  == tod_sec);
  assign eq_m = (al_min  == tod_min);
  assign eq_h = (al_hour == tod_hour);
  assign eq_d = (al_date == tod_date);
  assign mode = decode_repeat(flags);

  always_comb begin
    case (mode)
      RPT_MONTH:  hit = eq_d & eq_h & eq_m & eq_s;
      RPT_DAY:    hit = eq_h & eq_m & eq_s;
      RPT_HOUR:   hit = eq_m & eq_s;
      RPT_MINUTE: hit = eq_s;
      default:    hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/alarm_pulse.sv
module alarm_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= tick & hit;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr_en,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [6:0] tod_sec,
  input  logic [6:0] tod_min,
  input  logic [5:0] tod_hour,
  input  logic [5:0] tod_date,
  input  logic       sec_tick,
  output logic       alarm_irq
);
  logic [FIELD_CNT-1:0][BYTE_W-1:0] alm_regs;
  logic [3:0]                       rpt_flags;
  logic                             cmp_hit;

  alarm_regs #(.N_FIELDS(FIELD_CNT), .A_W(ADDR_W)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_addr),
    .wr_data (reg_wdata),
    .regs_q  (alm_regs)
  );

  assign reg_rdata = alm_regs[reg_addr];
  assign rpt_flags = {alm_regs[F_DATE][7], alm_regs[F_HOUR][7],
                      alm_regs[F_MIN][7],  alm_regs[F_SEC][7]};

  alarm_compare i_cmp (
    .al_sec   (alm_regs[F_SEC][6:0]),
    .al_min   (alm_regs[F_MIN][6:0]),
    .al_hour  (alm_regs[F_HOUR][5:0]),
    .al_date  (alm_regs[F_DATE][5:0]),
    .flags    (rpt_flags),
    .tod_sec  (tod_sec),
    .tod_min  (tod_min),
    .tod_hour (tod_hour),
    .tod_date (tod_date),
    .hit      (cmp_hit)
  );

  alarm_pulse i_pulse (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sec_tick),
    .hit   (cmp_hit),
    .irq   (alarm_irq)
  );
endmodule

// File: rtl/rtc_alarm_chk.sv
module rtc_alarm_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr_en,
  input logic [1:0]      reg_addr,
  input logic [7:0]      reg_wdata,
  input logic            sec_tick,
  input logic            alarm_irq,
  input logic [3:0][7:0] alm_regs
);
  // R6: reset clears the alarm bytes and holds the interrupt low
  a_r6_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (alarm_irq == 1'b0 && alm_regs == '0));

  // R12: no pulse unless a tick came in the cycle before
  a_r12_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(sec_tick));

  // R1: seconds tens digit of 6 or more is always out of range
  a_r1_sec_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd0 && reg_wdata[6:4] >= 3'd6) |=> $stable(alm_regs[0]));

  // R3: hours tens digit of 3 is always out of range
  a_r3_hour_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd2 && reg_wdata[5:4] == 2'd3) |=> $stable(alm_regs[2]));

  // R4: zero day of month is rejected
  a_r4_date_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd3 && reg_wdata[5:0] == 6'd0) |=> $stable(alm_regs[3]));

  // R11: seconds flag set with day flag clear repeats every tick
  a_r11_every_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alm_regs[0][7] && !alm_regs[3][7]) |=> alarm_irq);
endmodule

bind rtc_alarm_match rtc_alarm_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr_en (reg_wr_en),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sec_tick  (sec_tick),
  .alarm_irq (alarm_irq),
  .alm_regs  (alm_regs)
);

// File: tb/test_rtc_alarm_match.sv
module test_rtc_alarm_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr_en = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [6:0] tod_sec = 7'd0;
  logic [6:0] tod_min = 7'd0;
  logic [5:0] tod_hour = 6'd0;
  logic [5:0] tod_date = 6'd0;
  logic       sec_tick = 1'b0;
  logic       alarm_irq;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rtc_alarm_match i_rtc_alarm_match (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tod_sec(tod_sec),
    .tod_min(tod_min), .tod_hour(tod_hour), .tod_date(tod_date),
    .sec_tick(sec_tick), .alarm_irq(alarm_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  // tick with given time; irq is checked one cycle later, then must drop
  task automatic tick_chk(input string req, input logic [5:0] d, input logic [5:0] h,
                          input logic [6:0] m, input logic [6:0] s,
                          input logic tk, input logic exp);
    @(negedge clk);
    tod_date = d; tod_hour = h; tod_min = m; tod_sec = s; sec_tick = tk;
    @(negedge clk);
    sec_tick = 1'b0;
    chk(req, {7'd0, alarm_irq}, {7'd0, exp});
    @(negedge clk);
    chk({req, " pulse end"}, {7'd0, alarm_irq}, 8'd0);
  endtask

  task automatic t_reset;
    chk("R6 irq in reset", {7'd0, alarm_irq}, 8'd0);
    for (int i = 0; i < 4; i++) begin
      reg_addr = 2'(i); #1;
      chk("R6 reg in reset", reg_rdata, 8'd0);
    end
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_writes;
    wr(2'd0, 8'h59); rd_chk("R1 sec 59", 2'd0, 8'h59);
    wr(2'd0, 8'hE0); rd_chk("R1 sec 60 flagged rejected", 2'd0, 8'h59);
    wr(2'd0, 8'h5A); rd_chk("R1 sec decode 60 rejected", 2'd0, 8'h59);
    wr(2'd0, 8'hC5); rd_chk("R1 R5 sec with flag", 2'd0, 8'hC5);
    wr(2'd1, 8'h00); rd_chk("R2 min 00", 2'd1, 8'h00);
    wr(2'd1, 8'h7F); rd_chk("R2 min rejected", 2'd1, 8'h00);
    wr(2'd1, 8'h42); rd_chk("R2 min 42", 2'd1, 8'h42);
    wr(2'd2, 8'h23); rd_chk("R3 hour 23", 2'd2, 8'h23);
    wr(2'd2, 8'h24); rd_chk("R3 hour 24 rejected", 2'd2, 8'h23);
    wr(2'd2, 8'hB0); rd_chk("R3 hour 30 rejected", 2'd2, 8'h23);
    wr(2'd2, 8'h63); rd_chk("R3 R5 hour upper bits kept", 2'd2, 8'h63);
    wr(2'd3, 8'h31); rd_chk("R4 date 31", 2'd3, 8'h31);
    wr(2'd3, 8'h00); rd_chk("R4 date zero rejected", 2'd3, 8'h31);
    wr(2'd3, 8'hC0); rd_chk("R4 date zero flagged rejected", 2'd3, 8'h31);
  endtask

  task automatic t_month;
    wr(2'd0, 8'h30); wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h07);
    tick_chk("R7 monthly all match", 6'h07, 6'h12, 7'h15, 7'h30, 1'b1, 1'b1);
    tick_chk("R7 monthly date differs", 6'h08, 6'h12, 7'h15, 7'h30, 1'b1, 1'b0);
    tick_chk("R12 match without tick", 6'h07, 6'h12, 7'h15, 7'h30, 1'b0, 1'b0);
    wr(2'd3, 8'h80);  // rejected: flag must not take effect
    tick_chk("R4 rejected flag keeps monthly", 6'h08, 6'h12, 7'h15, 7'h30, 1'b1, 1'b0);
  endtask

  task automatic t_day;
    wr(2'd3, 8'h87);
    tick_chk("R8 daily date ignored", 6'h09, 6'h12, 7'h15, 7'h30, 1'b1, 1'b1);
    tick_chk("R8 daily hour differs", 6'h07, 6'h13, 7'h15, 7'h30, 1'b1, 1'b0);
  endtask

  task automatic t_hour;
    wr(2'd2, 8'h92);
    tick_chk("R9 hourly hour ignored", 6'h01, 6'h05, 7'h15, 7'h30, 1'b1, 1'b1);
    tick_chk("R9 hourly minute differs", 6'h07, 6'h12, 7'h16, 7'h30, 1'b1, 1'b0);
  endtask

  task automatic t_minute;
    wr(2'd1, 8'h95);
    tick_chk("R10 minute mode minute ignored", 6'h02, 6'h03, 7'h40, 7'h30, 1'b1, 1'b1);
    tick_chk("R10 minute mode second differs", 6'h07, 6'h12, 7'h15, 7'h31, 1'b1, 1'b0);
  endtask

  task automatic t_second;
    wr(2'd1, 8'h15); wr(2'd2, 8'h12); wr(2'd3, 8'h07); wr(2'd0, 8'hB0);
    tick_chk("R11 seconds flag alone fires", 6'h01, 6'h01, 7'h01, 7'h01, 1'b1, 1'b1);
    wr(2'd0, 8'h30); wr(2'd2, 8'h92);
    tick_chk("R11 hour flag alone fires", 6'h02, 6'h02, 7'h02, 7'h02, 1'b1, 1'b1);
    tick_chk("R12 no tick no pulse", 6'h02, 6'h02, 7'h02, 7'h02, 1'b0, 1'b0);
  endtask

  initial begin
    #1;
    t_reset;
    t_writes;
    t_month;
    t_day;
    t_hour;
    t_minute;
    t_second;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule